// File: doc/BRIEF.md
# Rename Stage Stall and Skid Controller

This block is the flow-control core of a superscalar register-rename stage. Each cycle it may receive a group of up to `W` instructions from decode. From later stages it receives a stall request, two squash indications and reported free counts for the reorder buffer and the issue queue. It also receives an external count of free physical registers. From these inputs it decides how many instructions of the group move forward this cycle. It packs those instructions into a registered output bundle and raises a stall back to decode whenever it cannot keep up.

The reported free counts are already stale by the feedback delay. The controller therefore takes `W * DELAY` away from each count before it uses them. When it stops part-way through a group, it stores the whole group in a small skid buffer and keeps the slot index where it stopped. After the blocking condition clears, it resumes that group from the saved index. The stall to decode stays high until the skid buffer is empty. A squash from commit discards everything buffered and holds the stage quiet until both squash indications drop.

Top module: `rename_skid_ctrl`

## Requirements
- R1: During and right after reset, `out_count_o` is 0, `out_insts_o` is all zero and `stall_o` is low.
- R2: Usable credit is the smaller of (`rob_free_i` − W·DELAY) and (`iq_free_i` − W·DELAY). At most that many slots of a group, and never more than W, are processed in one cycle.
- R3: When usable credit is zero or negative and a non-empty group arrives in the running state, nothing is forwarded. The group is buffered and `stall_o` is high in the following cycle.
- R4: When credit is positive but smaller than the slots left in the group, exactly that many slots are processed. The whole group is buffered with the stop index kept, and `stall_o` rises.
- R5: Forwarded instructions appear in program order, packed from output slot 0 (slot k occupies bits k·DATA_W upward). Slots at and above `out_count_o` are zero.
- R6: A slot whose `in_kill_i` bit is set is not forwarded. It still advances the group index and uses one unit of that cycle's credit. A group made only of killed slots completes without a stall.
- R7: A slot whose `in_dst_i` bit is set consumes one free register. When none remain, processing stops at that slot and the stage blocks.
- R8: While blocked, any arriving group is buffered and `stall_o` stays high. The stage moves on only when `down_stall_i` is low, both usable credits are above zero and `free_regs_i` is nonzero.
- R9: While unblocking, the oldest buffered group is processed from its saved index. A completed group is removed. `stall_o` stays high while groups remain, and the stage returns to normal operation once the buffer is empty.
- R10: `flush_i` or `rob_flushing_i` empties the skid buffer, clears the index and forwards nothing. Arriving groups are dropped, `stall_o` is low, and the stage leaves this state only in a cycle where both inputs are low.
- R11: The saved group index returns to zero only when a group has been processed to its end without an early stop.
- R12: The skid buffer never takes a group while full, and `stall_o` is high whenever it holds any group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_count_i | input | $clog2(W+1) | Number of valid slots in the arriving group (0 = none) |
| in_insts_i | input | W*DATA_W | Instruction payloads, slot 0 in the low bits |
| in_kill_i | input | W | Per-slot already-squashed flag |
| in_dst_i | input | W | Per-slot flag: slot needs a destination register |
| down_stall_i | input | 1 | Stall request from later stages |
| flush_i | input | 1 | Squash from commit |
| rob_flushing_i | input | 1 | Reorder buffer still squashing |
| rob_free_i | input | CNT_W | Reported free reorder-buffer entries |
| iq_free_i | input | CNT_W | Reported free issue-queue entries |
| free_regs_i | input | CNT_W | Free physical registers available |
| out_insts_o | output | W*DATA_W | Forwarded instructions, packed from slot 0 |
| out_count_o | output | $clog2(W+1) | Number of forwarded instructions this cycle |
| stall_o | output | 1 | Stall request to decode |

## Verification
The hardest case to reach is a resumed partial group with a second group queued behind it. The stage must pick up the first group at a nonzero index, pop it, and keep the stall high for the second group. Because `stall_o` is registered, decode can still deliver one group in the cycle after blocking begins. The stimulus uses that one-cycle window, with the issue-queue credit set to one and the first slot marked killed, so the killed slot uses up the only credit. The first group is then resumed at slot 1 while the later group waits in the buffer. Dropping stale buffered groups on a squash is checked by blocking and unblocking again after the squash, and confirming that only the fresh group comes out.

// File: rtl/rsk_pkg.sv
package rsk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RUN   = 3'd1,
    ST_BLK   = 3'd2,
    ST_UNBLK = 3'd3,
    ST_SQ    = 3'd4
  } state_e;

endpackage

// File: rtl/rsk_credit.sv
module rsk_credit #(
  parameter int W      = 4,
  parameter int DELAY  = 1,
  parameter int CNT_W  = 8,
  parameter int SLOT_W = $clog2(W + 1)
) (
  input  logic [CNT_W-1:0]  rob_free_i,
  input  logic [CNT_W-1:0]  iq_free_i,
  output logic              credit_ok_o,
  output logic [SLOT_W-1:0] limit_o
);
  localparam int SW   = CNT_W + 2;
  localparam int DISC = W * DELAY;

  logic signed [SW-1:0] rob_use, iq_use, use_min;

  // Reported counts lag by the feedback delay; discount in-flight slots.
  assign rob_use = $signed({2'b00, rob_free_i}) - $signed(SW'(DISC));
  assign iq_use  = $signed({2'b00, iq_free_i})  - $signed(SW'(DISC));
  assign use_min = (rob_use < iq_use) ? rob_use : iq_use;

  always_comb begin
    credit_ok_o = (use_min > $signed(SW'(0)));
    if (!credit_ok_o)
      limit_o = '0;
    else if (use_min >= $signed(SW'(W)))
      limit_o = SLOT_W'(W);
    else
      limit_o = use_min[SLOT_W-1:0];
  end
endmodule

// File: rtl/rsk_group_pick.sv
module rsk_group_pick #(
  parameter int W      = 4,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  parameter int SLOT_W = $clog2(W + 1)
) (
  input  logic [W*DATA_W-1:0] insts_i,
  input  logic [W-1:0]        kill_i,
  input  logic [W-1:0]        dst_i,
  input  logic [SLOT_W-1:0]   cnt_i,
  input  logic [SLOT_W-1:0]   start_i,
  input  logic [SLOT_W-1:0]   limit_i,
  input  logic [CNT_W-1:0]    regs_i,
  output logic [W*DATA_W-1:0] data_o,
  output logic [SLOT_W-1:0]   n_o,
  output logic [SLOT_W-1:0]   next_o,
  output logic                done_o
);
  logic [SLOT_W-1:0] budget, pos, n;
  logic [CNT_W-1:0]  regs;
  logic              stop;
  logic [W*DATA_W-1:0] data;

  // Walk slots in program order from start_i; pack survivors from slot 0.
  always_comb begin
    data   = '0;
    n      = '0;
    pos    = start_i;
    budget = limit_i;
    regs   = regs_i;
    stop   = 1'b0;
    for (int s = 0; s < W; s++) begin
      if (!stop && (SLOT_W'(s) >= start_i) && (SLOT_W'(s) < cnt_i)) begin
        if (budget == '0) begin
          stop = 1'b1;
        end else if (kill_i[s]) begin
          pos    = SLOT_W'(s + 1);
          budget = budget - 1'b1;
        end else if (dst_i[s] && (regs == '0)) begin
          stop = 1'b1;
        end else begin
          data[n*DATA_W +: DATA_W] = insts_i[s*DATA_W +: DATA_W];
          n      = n + 1'b1;
          if (dst_i[s]) regs = regs - 1'b1;
          budget = budget - 1'b1;
          pos    = SLOT_W'(s + 1);
        end
      end
    end
  end

  assign data_o = data;
  assign n_o    = n;
  assign next_o = pos;
  assign done_o = (pos >= cnt_i);
endmodule

// File: rtl/rsk_skid_fifo.sv
module rsk_skid_fifo #(
  parameter int DEPTH = 4,
  parameter int ENT_W = 80,
  parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [ENT_W-1:0] push_data_i,
  input  logic             pop_i,
  output logic [ENT_W-1:0] head_o,
  output logic [OCC_W-1:0] count_o,
  output logic             full_o
);
  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [OCC_W-1:0] count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Storage array without reset so it maps onto RAM resources.
  always_ff @(posedge clk) begin
    if (push_i) mem[wr_ptr] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_i) wr_ptr <= bump(wr_ptr);
      if (pop_i)  rd_ptr <= bump(rd_ptr);
      case ({push_i, pop_i})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_o  = mem[rd_ptr];
  assign count_o = count;
  assign full_o  = (count == OCC_W'(DEPTH));
endmodule

// File: rtl/rename_skid_ctrl.sv
module rename_skid_ctrl #(
  parameter int W      = 4,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  parameter int DELAY  = 1,
  parameter int DEPTH  = 4,
  parameter int SLOT_W = $clog2(W + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SLOT_W-1:0]   in_count_i,
  input  logic [W*DATA_W-1:0] in_insts_i,
  input  logic [W-1:0]        in_kill_i,
  input  logic [W-1:0]        in_dst_i,
  input  logic                down_stall_i,
  input  logic                flush_i,
  input  logic                rob_flushing_i,
  input  logic [CNT_W-1:0]    rob_free_i,
  input  logic [CNT_W-1:0]    iq_free_i,
  input  logic [CNT_W-1:0]    free_regs_i,
  output logic [W*DATA_W-1:0] out_insts_o,
  output logic [SLOT_W-1:0]   out_count_o,
  output logic                stall_o
);
  import rsk_pkg::*;

  localparam int PAY_W = W * DATA_W;
  localparam int ENT_W = PAY_W + 2 * W + SLOT_W;
  localparam int OCC_W = $clog2(DEPTH + 1);

  state_e            state_q, state_d;
  logic [SLOT_W-1:0] idx_q, idx_d;
  logic [PAY_W-1:0]  od_d;
  logic [SLOT_W-1:0] oc_d;
  logic              stall_d;

  logic              credit_ok;
  logic [SLOT_W-1:0] limit;

  logic [ENT_W-1:0]  skid_head, in_entry;
  logic [OCC_W-1:0]  skid_cnt;
  logic              skid_full, skid_push, skid_pop, skid_clr;

  logic [PAY_W-1:0]  h_insts, p_insts, pick_data;
  logic [W-1:0]      h_kill, h_dst, p_kill, p_dst;
  logic [SLOT_W-1:0] h_cnt, p_cnt, p_start, pick_n, pick_next;
  logic              pick_done, from_skid, in_has, flush_any, regs_ok;

  assign in_entry = {in_count_i, in_dst_i, in_kill_i, in_insts_i};
  assign h_insts  = skid_head[PAY_W-1:0];
  assign h_kill   = skid_head[PAY_W +: W];
  assign h_dst    = skid_head[PAY_W + W +: W];
  assign h_cnt    = skid_head[PAY_W + 2*W +: SLOT_W];

  assign in_has    = (in_count_i != '0);
  assign flush_any = flush_i | rob_flushing_i;
  assign regs_ok   = (free_regs_i != '0);
  assign from_skid = (state_q == ST_UNBLK);

  assign p_insts = from_skid ? h_insts : in_insts_i;
  assign p_kill  = from_skid ? h_kill  : in_kill_i;
  assign p_dst   = from_skid ? h_dst   : in_dst_i;
  assign p_cnt   = from_skid ? h_cnt   : in_count_i;
  assign p_start = from_skid ? idx_q   : '0;

  rsk_credit #(.W(W), .DELAY(DELAY), .CNT_W(CNT_W), .SLOT_W(SLOT_W)) credit_i (
    .rob_free_i (rob_free_i),
    .iq_free_i  (iq_free_i),
    .credit_ok_o(credit_ok),
    .limit_o    (limit)
  );

  rsk_group_pick #(.W(W), .DATA_W(DATA_W), .CNT_W(CNT_W), .SLOT_W(SLOT_W)) pick_i (
    .insts_i(p_insts),
    .kill_i (p_kill),
    .dst_i  (p_dst),
    .cnt_i  (p_cnt),
    .start_i(p_start),
    .limit_i(limit),
    .regs_i (free_regs_i),
    .data_o (pick_data),
    .n_o    (pick_n),
    .next_o (pick_next),
    .done_o (pick_done)
  );

  rsk_skid_fifo #(.DEPTH(DEPTH), .ENT_W(ENT_W)) skid_i (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (skid_clr),
    .push_i     (skid_push),
    .push_data_i(in_entry),
    .pop_i      (skid_pop),
    .head_o     (skid_head),
    .count_o    (skid_cnt),
    .full_o     (skid_full)
  );

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    oc_d      = '0;
    od_d      = '0;
    stall_d   = 1'b0;
    skid_push = 1'b0;
    skid_pop  = 1'b0;
    skid_clr  = 1'b0;
    if (flush_any) begin
      skid_clr = 1'b1;
      idx_d    = '0;
      state_d  = ST_SQ;
    end else begin
      case (state_q)
        ST_IDLE, ST_RUN: begin
          if (down_stall_i) begin
            skid_push = in_has;
            state_d   = ST_BLK;
            stall_d   = 1'b1;
          end else if (!in_has) begin
            state_d = ST_IDLE;
          end else if (!credit_ok) begin
            skid_push = 1'b1;
            state_d   = ST_BLK;
            stall_d   = 1'b1;
          end else begin
            oc_d = pick_n;
            od_d = pick_data;
            if (pick_done) begin
              idx_d   = '0;
              state_d = ST_RUN;
            end else begin
              skid_push = 1'b1;
              idx_d     = pick_next;
              state_d   = ST_BLK;
              stall_d   = 1'b1;
            end
          end
        end
        ST_BLK: begin
          skid_push = in_has;
          stall_d   = 1'b1;
          if (!down_stall_i && credit_ok && regs_ok) begin
            if (skid_cnt == '0 && !in_has) begin
              state_d = ST_RUN;
              stall_d = 1'b0;
            end else begin
              state_d = ST_UNBLK;
            end
          end
        end
        ST_UNBLK: begin
          skid_push = in_has;
          stall_d   = 1'b1;
          if (skid_cnt == '0) begin
            state_d = in_has ? ST_UNBLK : ST_RUN;
            stall_d = in_has;
          end else if (down_stall_i || !credit_ok) begin
            state_d = ST_BLK;
          end else begin
            oc_d = pick_n;
            od_d = pick_data;
            if (pick_done) begin
              skid_pop = 1'b1;
              idx_d    = '0;
              if (skid_cnt == OCC_W'(1) && !in_has) begin
                state_d = ST_RUN;
                stall_d = 1'b0;
              end
            end else begin
              idx_d   = pick_next;
              state_d = ST_BLK;
            end
          end
        end
        ST_SQ: begin
          state_d = ST_RUN;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      out_insts_o <= '0;
      out_count_o <= '0;
      stall_o     <= 1'b0;
    end else begin
      state_q     <= state_d;
      idx_q       <= idx_d;
      out_insts_o <= od_d;
      out_count_o <= oc_d;
      stall_o     <= stall_d;
    end
  end
endmodule

// File: rtl/rename_skid_ctrl_chk.sv
module rename_skid_ctrl_chk #(
  parameter int W      = 4,
  parameter int DEPTH  = 4,
  parameter int SLOT_W = $clog2(W + 1),
  parameter int OCC_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input rsk_pkg::state_e   state_q,
  input logic [OCC_W-1:0]  skid_cnt,
  input logic              skid_push,
  input logic              skid_pop,
  input logic              skid_full,
  input logic              credit_ok,
  input logic              stall_o,
  input logic [SLOT_W-1:0] out_count_o,
  input logic [SLOT_W-1:0] in_count_i,
  input logic              down_stall_i,
  input logic              flush_i,
  input logic              rob_flushing_i
);
  import rsk_pkg::*;

  // R12: a full buffer only takes a group when one leaves at the same edge
  p_no_overflow_r12: assert property (@(posedge clk) disable iff (rst)
    (skid_push && skid_full) |-> skid_pop);

  // R9 / R12: buffered groups keep decode stalled
  p_skid_stall_r9: assert property (@(posedge clk) disable iff (rst)
    (skid_cnt != '0) |-> stall_o);

  // R10: squash cycle forwards nothing and releases decode
  p_squash_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (flush_i || rob_flushing_i) |=> (out_count_o == '0 && !stall_o));

  // R3: no credit in normal operation blocks with nothing forwarded
  p_no_credit_r3: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_RUN || state_q == ST_IDLE) && !flush_i && !rob_flushing_i &&
     !down_stall_i && in_count_i != '0 && !credit_ok)
    |=> (out_count_o == '0 && stall_o));

  // R2: never more than a group's width per cycle
  p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
    out_count_o <= SLOT_W'(W));
endmodule

bind rename_skid_ctrl rename_skid_ctrl_chk #(.W(W), .DEPTH(DEPTH)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .state_q       (state_q),
  .skid_cnt      (skid_cnt),
  .skid_push     (skid_push),
  .skid_pop      (skid_pop),
  .skid_full     (skid_full),
  .credit_ok     (credit_ok),
  .stall_o       (stall_o),
  .out_count_o   (out_count_o),
  .in_count_i    (in_count_i),
  .down_stall_i  (down_stall_i),
  .flush_i       (flush_i),
  .rob_flushing_i(rob_flushing_i)
);

// File: tb/rename_skid_ctrl_tb_top.sv
`timescale 1ns/1ps
module rename_skid_ctrl_tb_top;
  localparam int W = 4;
  localparam int DATA_W = 16;
  localparam int NV = 24;

  typedef struct packed {
    logic [2:0]  cnt;
    logic [3:0]  kill;
    logic [3:0]  dst;
    logic        dstall;
    logic        fl;
    logic        rfl;
    logic [7:0]  rob;
    logic [7:0]  iq;
    logic [7:0]  regs;
    logic [2:0]  ecnt;
    logic        estall;
    logic [15:0] e0;
    logic [15:0] e1;
  } vec_t;

  // Credit = free - 4 (W*DELAY). Payload of slot s in vector v is {v, s}.
  localparam vec_t VEC [NV] = '{
    '{3'd4, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 8'd20, 8'd20, 8'd10, 3'd4, 1'b0, 16'h0000, 16'h0001},
    '{3'd3, 4'h2, 4'h0, 1'b0, 1'b0, 1'b0, 8'd20, 8'd20, 8'd10, 3'd2, 1'b0, 16'h0100, 16'h0102},
    '{3'd4, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 8'd6,  8'd20, 8'd10, 3'd2, 1'b1, 16'h0200, 16'h0201},
    '{3'd0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 8'd20, 8'd20, 8'd10, 3'd0, 1'b1, 16'h0000, 16'h0000},
    '{3'd0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 8'd20, 8'd20, 8'd10, 3'd2, 1'b0, 16'h0202, 16'h0203},
    '{3'd4, 4'h0, 4'h0, 1'b1, 1'b0, 1'b0, 8'd20, 8'd20, 8'd10, 3'd0, 1'b1, 16'h0000, 16'h0000},
    '{3'd0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 8'd20, 8'd20, 8'd10, 3'd0, 1'b1, 16'h0000, 16'h0000},
    '{3'd0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 8'd20, 8'd20, 8'd10, 3'd4, 1'b0, 16'h0500, 16'h0501},
    '{3'd4, 4'h0, 4'hF, 1'b0, 1'b0, 1'b0, 8'd20, 8'd20, 8'd1,  3'd1, 1'b1, 16'h0800, 16'h0000},
    '{3'd0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 8'd20, 8'd20, 8'd1,  3'd0, 1'b1, 16'h0000, 16'h0000},
    '{3'd0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 8'd20, 8'd20, 8'd10, 3'd3, 1'b0, 16'h0801, 16'h0802},
    '{3'd4, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 8'd4,  8'd20, 8'd10, 3'd0, 1'b1, 16'h0000, 16'h0000},
    '{3'd0, 4'h0, 4'h0, 1'b0, 1'b1, 1'b0, 8'd20, 8'd20, 8'd10, 3'd0, 1'b0, 16'h0000, 16'h0000},
    '{3'd4, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 8'd20, 8'd20, 8'd10, 3'd0, 1'b0, 16'h0000, 16'h0000},
    '{3'd0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 8'd20, 8'd20, 8'd10, 3'd0, 1'b0, 16'h0000, 16'h0000},
    '{3'd2, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 8'd20, 8'd20, 8'd10, 3'd2, 1'b0, 16'h0F00, 16'h0F01},
    '{3'd4, 4'h0, 4'h0, 1'b1, 1'b0, 1'b0, 8'd20, 8'd20, 8'd10, 3'd0, 1'b1, 16'h0000, 16'h0000},
    '{3'd0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 8'd20, 8'd20, 8'd10, 3'd0, 1'b1, 16'h0000, 16'h0000},
    '{3'd0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 8'd20, 8'd20, 8'd10, 3'd4, 1'b0, 16'h1000, 16'h1001},
    '{3'd4, 4'hF, 4'h0, 1'b0, 1'b0, 1'b0, 8'd20, 8'd20, 8'd10, 3'd0, 1'b0, 16'h0000, 16'h0000},
    '{3'd4, 4'h1, 4'h0, 1'b0, 1'b0, 1'b0, 8'd20, 8'd5,  8'd10, 3'd0, 1'b1, 16'h0000, 16'h0000},
    '{3'd4, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 8'd20, 8'd5,  8'd10, 3'd0, 1'b1, 16'h0000, 16'h0000},
    '{3'd0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 8'd20, 8'd20, 8'd10, 3'd3, 1'b1, 16'h1401, 16'h1402},
    '{3'd0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 8'd20, 8'd20, 8'd10, 3'd4, 1'b0, 16'h1500, 16'h1501}
  };

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [2:0]          in_count = '0;
  logic [W*DATA_W-1:0] in_insts = '0;
  logic [W-1:0]        in_kill = '0, in_dst = '0;
  logic                down_stall = 1'b0, flush = 1'b0, rob_flushing = 1'b0;
  logic [7:0]          rob_free = 8'd20, iq_free = 8'd20, free_regs = 8'd10;
  logic [W*DATA_W-1:0] out_insts;
  logic [2:0]          out_count;
  logic                stall;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rename_skid_ctrl dut_i (
    .clk(clk), .rst(rst), .in_count_i(in_count), .in_insts_i(in_insts),
    .in_kill_i(in_kill), .in_dst_i(in_dst), .down_stall_i(down_stall),
    .flush_i(flush), .rob_flushing_i(rob_flushing), .rob_free_i(rob_free),
    .iq_free_i(iq_free), .free_regs_i(free_regs), .out_insts_o(out_insts),
    .out_count_o(out_count), .stall_o(stall)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int v);
    case (v)
      0: return "R2";
      1: return "R5";
      2: return "R4";
      3, 5, 6, 9, 16, 17: return "R8";
      4, 7, 22, 23: return "R9";
      8: return "R7";
      10: return "R11";
      11: return "R3";
      12, 13, 14, 15, 18: return "R10";
      19, 20: return "R6";
      default: return "R12";
    endcase
  endfunction

  task automatic apply(input int v, input vec_t t);
    in_count = t.cnt; in_kill = t.kill; in_dst = t.dst;
    down_stall = t.dstall; flush = t.fl; rob_flushing = t.rfl;
    rob_free = t.rob; iq_free = t.iq; free_regs = t.regs;
    for (int s = 0; s < W; s++) in_insts[s*DATA_W +: DATA_W] = {v[7:0], s[7:0]};
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "reset count", int'(out_count), 0);
    check("R1", "reset stall", int'(stall), 0);
    check("R1", "reset data", int'(out_insts[31:0]), 0);
    rst = 1'b0;
    for (int v = 0; v < NV; v++) begin
      apply(v, VEC[v]);
      @(posedge clk);
      @(negedge clk);
      check(tag_of(v), $sformatf("v%0d count", v), int'(out_count), int'(VEC[v].ecnt));
      check(tag_of(v), $sformatf("v%0d stall", v), int'(stall), int'(VEC[v].estall));
      check(tag_of(v), $sformatf("v%0d slot0", v), int'(out_insts[15:0]), int'(VEC[v].e0));
      check(tag_of(v), $sformatf("v%0d slot1", v), int'(out_insts[31:16]), int'(VEC[v].e1));
    end
    // R2: both credits discounted by 4; ROB gives 2, IQ gives 3 -> 2 forwarded
    apply(24, '{3'd4, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 8'd6, 8'd7, 8'd10,
                3'd0, 1'b0, 16'h0, 16'h0});
    @(posedge clk);
    @(negedge clk);
    check("R2", "min credit count", int'(out_count), 2);
    check("R2", "min credit slot1", int'(out_insts[31:16]), 16'h1801);
    check("R2", "min credit slot2 zero", int'(out_insts[47:32]), 0);
    check("R4", "partial stall", int'(stall), 1);
    // R1: reset from a blocked state
    in_count = '0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1", "reset while blocked stall", int'(stall), 0);
    check("R1", "reset while blocked count", int'(out_count), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule